// File: doc/BRIEF.md
# Cascaded 16-bit Event Counter

This block counts falling edges on an external, asynchronous event line and raises an interrupt once a programmed number of edges has been seen. The count is held in two 8-bit slices joined by a carry chain, so together they form a 16-bit up-counter. The count is compared against a 16-bit match value. When the next edge would bring the count equal to that value, the block emits a one-clock interrupt pulse and the count returns to zero. Counting then carries on from zero with the following edge.

The event line first passes through a synchronizer. The falling edge is then sampled only on cycles where the machine-cycle enable is high. This means each high and each low level of the event line must last at least two machine cycles to be counted reliably.

The match value is written one byte at a time through a narrow write port, low byte first and then high byte. It is not shadowed: each byte takes effect on the next clock. A start/stop bit enables counting. While the bit is clear, the count is held at zero, so setting the bit always starts from a cleared count.

Top module: `evc_event_counter16`

## Requirements
- R1: A synchronous reset clears the count, the match value (to 0x0000) and the interrupt output. With a match value of zero, no interrupt occurs within the first 65535 edges.
- R2: Only a high-to-low transition of the synchronized event line, seen on a machine-cycle enable, advances the count by one. Rising edges and steady levels of any length leave the count unchanged.
- R3: When an edge brings the count to the match value, the interrupt fires and the count becomes zero. The next interrupt follows after another full match-value number of edges.
- R4: The low slice carries into the high slice, and the match test covers all 16 bits. With a match value of 0x0102, the interrupt fires on edge 258 and on no earlier edge.
- R5: While the start bit is 0, the count is held at zero, edges are ignored and no interrupt is raised. After the bit is set again, the first interrupt needs a full match-value number of fresh edges.
- R6: A write with byte select 0 loads match bits 7:0. A write with byte select 1 loads bits 15:8. The new value applies from the next clock, even while counting is in progress.
- R7: The interrupt output is high for exactly one clock per match.
- R8: An edge whose whole low level falls in a span where the machine-cycle enable stays low is not counted. Levels that each last four machine cycles are all counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mce_i | input | 1 | Machine-cycle enable, one clock wide |
| run_i | input | 1 | Start/stop bit; 1 counts, 0 holds the count at zero |
| evt_i | input | 1 | Raw asynchronous event line |
| wr_en_i | input | 1 | Match-byte write strobe |
| wr_sel_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data_i | input | 8 | Match byte data |
| irq_o | output | 1 | Interrupt pulse on a match |

## Verification
The count itself is not visible at the ports, so a wrong count, a lost carry or a stale match byte shows up only as an interrupt on the wrong edge. The bench checks the interrupt after every single event pulse, against the edge number it expects. A fault is therefore caught at the first pulse that fires too early, or at the match pulse that does not fire. This is at most one match period after the fault. A pulse wider than one clock is caught on the clock that follows it.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Width of one counter slice and of one match-register byte.
    localparam int SLICE_W = 8;

    // Counter width built from slices.
    localparam int COUNT_W = 16;

    // Minimum depth of the input synchronizer.
    localparam int MIN_SYNC = 2;

    typedef logic [SLICE_W-1:0] slice_t;

endpackage

// File: rtl/evc_edge_detect.sv
module evc_edge_detect #(
    parameter int SYNC_STAGES = evc_pkg::MIN_SYNC
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mce_i,
    input  logic evt_i,
    output logic fall_o
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [TOP:0] sync;
        logic         last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Shift the raw line into the synchronizer every clock.
        st_d.sync = {st_q.sync[TOP-1:0], evt_i};
        // The reference level only moves on a machine cycle.
        if (mce_i) begin
            st_d.last = st_q.sync[TOP];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            // Reference starts low so a line held low through reset
            // does not look like an edge.
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = mce_i & st_q.last & ~st_q.sync[TOP];

endmodule

// File: rtl/evc_slice.sv
module evc_slice #(
    parameter int W = evc_pkg::SLICE_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic [W-1:0] match_i,
    output logic [W-1:0] val_o,
    output logic         eq_o
);

    logic [W-1:0] val_d, val_q;
    logic [W-1:0] bumped;

    always_comb begin
        bumped = inc_i ? val_q + W'(1) : val_q;
        eq_o   = (bumped == match_i);
        val_d  = clr_i ? '0 : bumped;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/evc_match_reg.sv
module evc_match_reg #(
    parameter int W     = evc_pkg::SLICE_W,
    parameter int NUM   = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [W-1:0]     wr_data_i,
    output logic [NUM*W-1:0] match_o
);

    logic [NUM*W-1:0] match_d, match_q;

    always_comb begin
        match_d = match_q;
        for (int k = 0; k < NUM; k++) begin
            if (wr_en_i && (int'(wr_sel_i) == k)) begin
                match_d[k*W +: W] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            match_q <= '0;
        end else begin
            match_q <= match_d;
        end
    end

    assign match_o = match_q;

endmodule

// File: rtl/evc_event_counter16.sv
module evc_event_counter16 #(
    parameter int CNT_W       = evc_pkg::COUNT_W,
    parameter int SLICE_W     = evc_pkg::SLICE_W,
    parameter int SYNC_STAGES = evc_pkg::MIN_SYNC,
    localparam int NUM_SLICES = CNT_W / SLICE_W,
    localparam int SEL_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               mce_i,
    input  logic               run_i,
    input  logic               evt_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [SLICE_W-1:0] wr_data_i,
    output logic               irq_o
);

    typedef struct packed {
        logic irq;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic                  evt_fall;
    logic [CNT_W-1:0]      match_val;
    logic [CNT_W-1:0]      count_q;
    logic [NUM_SLICES-1:0] slice_eq;
    logic [NUM_SLICES-1:0] slice_inc;
    logic                  hit;
    logic                  clr_all;

    evc_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .mce_i (mce_i),
        .evt_i (evt_i),
        .fall_o(evt_fall)
    );

    evc_match_reg #(
        .W    (SLICE_W),
        .NUM  (NUM_SLICES),
        .SEL_W(SEL_W)
    ) u_match (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_data_i(wr_data_i),
        .match_o  (match_val)
    );

    // Ripple enable: a slice advances when every slice below it is full.
    assign slice_inc[0] = evt_fall & run_i;

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        if (g > 0) begin : g_carry
            assign slice_inc[g] = slice_inc[g-1]
                                & (count_q[(g-1)*SLICE_W +: SLICE_W] == {SLICE_W{1'b1}});
        end
        evc_slice #(
            .W(SLICE_W)
        ) u_slice (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .inc_i  (slice_inc[g]),
            .clr_i  (clr_all),
            .match_i(match_val[g*SLICE_W +: SLICE_W]),
            .val_o  (count_q[g*SLICE_W +: SLICE_W]),
            .eq_o   (slice_eq[g])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        hit       = slice_inc[0] & (&slice_eq);
        clr_all   = ~run_i | hit;
        ctl_d.irq = hit;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_o = ctl_q.irq;

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int CNT_W = evc_pkg::COUNT_W
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             run_i,
    input logic             fall_i,
    input logic             irq_o,
    input logic [CNT_W-1:0] count_i
);

    // R7: interrupt never lasts two clocks
    a_r7_irq_one_clock: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> !irq_o);

    // R5: a cleared start bit empties the count
    a_r5_stop_zeroes: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (count_i == '0));

    // R5: no interrupt while stopped
    a_r5_stop_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> !irq_o);

    // R3: an interrupt leaves the count at zero
    a_r3_irq_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (count_i == '0));

    // R3: an interrupt follows a detected edge
    a_r3_irq_after_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> $past(fall_i));

    // R2: without an edge the count stays put
    a_r2_hold_no_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !fall_i) |=> $stable(count_i));

    // R2: an edge advances by one or wraps to zero on a match
    a_r2_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && fall_i) |=>
            ((count_i == CNT_W'($past(count_i) + 1'b1)) || (count_i == '0)));

endmodule

bind evc_event_counter16 evc_checker #(
    .CNT_W(CNT_W)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (run_i),
    .fall_i (evt_fall),
    .irq_o  (irq_o),
    .count_i(count_q)
);

// File: tb/tb_evc_event_counter16.sv
module tb_evc_event_counter16;

    localparam int CLK_PERIOD = 10;
    localparam int LEVEL_CLKS = 8;

    logic       clk_i     = 1'b0;
    logic       rst_i     = 1'b1;
    logic       mce_i     = 1'b0;
    logic       run_i     = 1'b0;
    logic       evt_i     = 1'b1;
    logic       wr_en_i   = 1'b0;
    logic       wr_sel_i  = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       irq_o;

    int   vectors     = 0;
    int   miscompares = 0;
    int   irq_total   = 0;
    logic irq_prev    = 1'b0;
    bit   mce_on      = 1'b1;

    bit    exp_q[$];
    int    base_q[$];
    string tag_q[$];
    event  pulse_done;

    evc_event_counter16 dut (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .mce_i    (mce_i),
        .run_i    (run_i),
        .evt_i    (evt_i),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_data_i(wr_data_i),
        .irq_o    (irq_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    // Machine cycle = two clocks; may be paused by the stimulus.
    always @(negedge clk_i) mce_i <= mce_on ? ~mce_i : 1'b0;

    // Monitor: counts interrupt pulses and checks their width (R7).
    always @(negedge clk_i) begin
        if (!rst_i && irq_o) begin
            irq_total++;
            vectors++;
            if (irq_prev) begin
                miscompares++;
                $display("FAIL R7 irq width: actual 2+ clocks expected 1");
            end
        end
        irq_prev = irq_o;
    end

    // Scoreboard: pop expected items and compare with observed pulses.
    initial forever begin
        @(pulse_done);
        while (exp_q.size() > 0) begin
            automatic bit    want = exp_q.pop_front();
            automatic int    base = base_q.pop_front();
            automatic string tag  = tag_q.pop_front();
            automatic int    got  = irq_total - base;
            vectors++;
            if (got != int'(want)) begin
                miscompares++;
                $display("FAIL %s: irq count actual %0d expected %0d", tag, got, want);
            end
        end
    end

    task automatic pulse_len(input int low_clks, input bit want, input string tag);
        int base;
        @(negedge clk_i); #1;
        base  = irq_total;
        evt_i = 1'b0;
        repeat (low_clks) @(negedge clk_i);
        evt_i = 1'b1;
        repeat (LEVEL_CLKS) @(negedge clk_i);
        #1;
        exp_q.push_back(want);
        base_q.push_back(base);
        tag_q.push_back(tag);
        -> pulse_done;
        #1;
    endtask

    task automatic pulse(input bit want, input string tag);
        pulse_len(LEVEL_CLKS, want, tag);
    endtask

    task automatic write_match(input logic [15:0] v);
        @(negedge clk_i);
        wr_en_i   = 1'b1;
        wr_sel_i  = 1'b0;
        wr_data_i = v[7:0];
        @(negedge clk_i);
        wr_sel_i  = 1'b1;
        wr_data_i = v[15:8];
        @(negedge clk_i);
        wr_en_i   = 1'b0;
    endtask

    task automatic stop_run();
        @(negedge clk_i);
        run_i = 1'b0;
        repeat (2) @(negedge clk_i);
    endtask

    task automatic start_run();
        @(negedge clk_i);
        run_i = 1'b1;
        repeat (2) @(negedge clk_i);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk_i);
        rst_i = 1'b0;
        @(negedge clk_i);
        vectors++;
        if (irq_o !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset irq: actual %b expected 0", irq_o);
        end

        // R1: match value resets to zero, so a few edges give no interrupt
        start_run();
        for (int i = 0; i < 3; i++) pulse(1'b0, "R1 reset match");

        // R3 / R2: match of 3, two full periods
        stop_run();
        write_match(16'd3);
        start_run();
        for (int i = 0; i < 2; i++) begin
            pulse(1'b0, "R3 period");
            pulse(1'b0, "R3 period");
            pulse(1'b1, "R3 match");
        end

        // R2: a long low level is one edge only
        stop_run();
        write_match(16'd2);
        start_run();
        pulse_len(LEVEL_CLKS * 6, 1'b0, "R2 long level");
        pulse(1'b1, "R2 second edge");

        // R6: match of one written while running, every edge fires
        write_match(16'd1);
        pulse(1'b1, "R6 match one");
        pulse(1'b1, "R6 match one");

        // R4: carry into the high slice, 0x0102 fires on edge 258
        stop_run();
        write_match(16'h0102);
        start_run();
        for (int i = 1; i < 258; i++) pulse(1'b0, "R4 below match");
        pulse(1'b1, "R4 edge 258");

        // R5: stopping discards the partial count and ignores edges
        stop_run();
        write_match(16'd3);
        start_run();
        pulse(1'b0, "R5 before stop");
        pulse(1'b0, "R5 before stop");
        stop_run();
        for (int i = 0; i < 4; i++) pulse(1'b0, "R5 while stopped");
        start_run();
        pulse(1'b0, "R5 restart");
        pulse(1'b0, "R5 restart");
        pulse(1'b1, "R5 restart match");

        // R6: lowering the match mid-count takes effect at once
        stop_run();
        write_match(16'd10);
        start_run();
        for (int i = 0; i < 4; i++) pulse(1'b0, "R6 old match");
        write_match(16'd5);
        pulse(1'b1, "R6 new match");

        // R8: edge hidden while the machine-cycle enable is paused
        stop_run();
        write_match(16'd2);
        start_run();
        pulse(1'b0, "R8 first edge");
        @(negedge clk_i);
        mce_on = 1'b0;
        repeat (2) @(negedge clk_i);
        pulse(1'b0, "R8 paused edge");
        mce_on = 1'b1;
        repeat (2) @(negedge clk_i);
        pulse(1'b1, "R8 second counted");

        repeat (4) @(negedge clk_i);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule